// File: doc/BRIEF.md
# Page-Pointer Scatter List Walker

This block turns one transfer descriptor (a byte count plus two physical page pointers) into an ordered stream of address/length segments for a DMA engine. The first pointer may sit at any byte offset within a page and covers the bytes up to the next page boundary. Any remaining bytes come from the second pointer. If the remainder fits in one page, the second pointer is a data page. Otherwise it addresses a list of 64-bit page entries, which the block fetches through a read request port.

Entries come back one per beat and are consumed in order. Each valid entry becomes one segment. When the final slot of a full list page is reached and more than one page is still owed, that slot is taken as the address of the next list page rather than as data. At the end the block reports one completion, either success or an invalid-field error with the do-not-retry flag set. The page size is 2^(12 + `page_sel`). The data movement itself is done elsewhere.

Top module: `prp_walker`

## Requirements
- R1: A `start` seen while idle whose `first_ptr` is zero completes with `done_code` = 0x02 and `done_dnr` = 1, with no segments and no read requests.
- R2: The first segment has address `first_ptr` and length min(`xfer_len`, P - (`first_ptr` mod P)), where P = 2^(12 + `page_sel`).
- R3: If 1 to P bytes remain after the first segment, exactly one more segment is emitted at `second_ptr` with the remaining length and no read is issued. If `second_ptr` is not P-aligned here, the walk ends with the R1 error code instead.
- R4: If bytes remain after the first segment and `second_ptr` is zero, the walk ends with the R1 error code and nothing more is emitted.
- R5: If more than P bytes remain, a read request is issued at `second_ptr` for min(P/8, ceil(remaining/P)) entries. Each response beat carries one entry as a 64-bit little-endian value, so bit 0 of `rsp_data` is the entry's bit 0. Entries are returned in list order.
- R6: Each entry used as data gives one segment at the entry's value, with length min(remaining, P), in list order.
- R7: The entry in slot P/8-1 of a list page is a chain pointer when more than P bytes remain at that point. A new read request is then issued at its value, and slot counting restarts at 0. With P bytes or fewer remaining, that slot is used as data.
- R8: A list entry that is zero or not P-aligned, whether data or chain, ends the walk with the R1 error code and no further segments. The beats still owed from that burst are accepted before completion.
- R9: After the last segment is accepted, the walk completes with `done_code` = 0x00 and `done_dnr` = 0. A zero `xfer_len` with a nonzero `first_ptr` completes this way with no segments.
- R10: `seg_addr`/`seg_len` and `rd_req_addr`/`rd_req_beats` stay unchanged while valid and not accepted. `done` is a one-cycle pulse per walk, and `start` has no effect until that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (sampled only while idle) |
| first_ptr | input | ADDR_W | First page pointer, any offset |
| second_ptr | input | ADDR_W | Second pointer: data page or list address |
| xfer_len | input | LEN_W | Total bytes to describe |
| page_sel | input | 4 | Page size exponent minus 12 |
| seg_valid | output | 1 | Segment available |
| seg_ready | input | 1 | Segment accepted by consumer |
| seg_addr | output | ADDR_W | Segment start address |
| seg_len | output | LEN_W | Segment byte count |
| rd_req_valid | output | 1 | List read request valid |
| rd_req_ready | input | 1 | List read request accepted |
| rd_req_addr | output | ADDR_W | Address of first entry to read |
| rd_req_beats | output | LEN_W | Number of 64-bit entries to read |
| rsp_valid | input | 1 | Entry beat valid |
| rsp_ready | output | 1 | Entry beat accepted |
| rsp_data | input | 64 | One list entry, little-endian |
| done | output | 1 | One-cycle completion pulse |
| done_dnr | output | 1 | Do-not-retry flag of the completion |
| done_code | output | 8 | 0x00 success, 0x02 invalid field |

## Verification
The sweep targets first-pointer offsets at the page edges, including lengths that exactly fill the first page and lengths that leave one byte over. A head-length error would show there as an off-by-one segment or a stray second segment. The boundary between direct use of the second pointer and list mode (exactly one page left versus one page plus one byte) catches a design that issues a needless read or skips one. The list cases include one that fills all P/8 slots without chaining and one that needs a chain. A walker that chains on the wrong slot would emit the chain pointer as data, or take a data page as a list. Bad entries placed early in a long burst and on the chain slot check that emission stops and the owed beats are drained; a walker that skips the drain would hang the response channel.

// File: rtl/prp_walk_pkg.sv
package prp_walk_pkg;

    localparam int ENT_W = 64;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_TAIL,
        ST_LREQ,
        ST_LENT,
        ST_LSEG,
        ST_DRAIN,
        ST_FIN
    } walk_st_e;

    localparam logic [7:0] CODE_OK        = 8'h00;
    localparam logic [7:0] CODE_BAD_FIELD = 8'h02;

    typedef struct packed {
        logic       dnr;
        logic [7:0] code;
    } walk_status_t;

    function automatic logic [4:0] pg_shift(input logic [3:0] sel);
        return 5'd12 + {1'b0, sel};
    endfunction

endpackage

// File: rtl/prp_seg_math.sv
module prp_seg_math import prp_walk_pkg::*; #(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 32
) (
    input  logic [3:0]        page_sel,
    input  logic [ADDR_W-1:0] head_ptr,
    input  logic [LEN_W-1:0]  rem,
    output logic [LEN_W-1:0]  pg_size,
    output logic [LEN_W-1:0]  head_len,
    output logic [LEN_W-1:0]  cap_len,
    output logic [LEN_W-1:0]  burst_n,
    output logic [LEN_W-1:0]  slot_last,
    output logic              rem_gt_pg
);
    logic [4:0]       shift;
    logic [LEN_W-1:0] offset;
    logic [LEN_W-1:0] room;
    logic [LEN_W:0]   round_up;
    logic [LEN_W-1:0] pages;
    logic [LEN_W-1:0] per_page;

    always_comb begin
        shift     = pg_shift(page_sel);
        pg_size   = {{(LEN_W-1){1'b0}}, 1'b1} << shift;
        offset    = head_ptr[LEN_W-1:0] & (pg_size - 1'b1);
        room      = pg_size - offset;
        head_len  = (rem < room) ? rem : room;
        cap_len   = (rem < pg_size) ? rem : pg_size;
        rem_gt_pg = rem > pg_size;
        round_up  = {1'b0, rem} + {1'b0, pg_size} - 1'b1;
        pages     = round_up[LEN_W-1:0] >> shift;
        if (round_up[LEN_W]) begin
            pages = pages | ({{(LEN_W-1){1'b0}}, 1'b1} << (LEN_W[4:0] - shift));
        end
        per_page  = pg_size >> 3;
        burst_n   = (pages < per_page) ? pages : per_page;
        slot_last = per_page - 1'b1;
    end
endmodule

// File: rtl/prp_ptr_check.sv
module prp_ptr_check import prp_walk_pkg::*; #(
    parameter int ADDR_W = 64
) (
    input  logic [3:0]        page_sel,
    input  logic [ADDR_W-1:0] ptr,
    output logic              usable
);
    logic [ADDR_W-1:0] low_mask;

    always_comb begin
        low_mask = ({{(ADDR_W-1){1'b0}}, 1'b1} << pg_shift(page_sel)) - 1'b1;
        usable   = (ptr != '0) && ((ptr & low_mask) == '0);
    end
endmodule

// File: rtl/prp_walker.sv
module prp_walker import prp_walk_pkg::*; #(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] first_ptr,
    input  logic [ADDR_W-1:0] second_ptr,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic [3:0]        page_sel,
    output logic              seg_valid,
    input  logic              seg_ready,
    output logic [ADDR_W-1:0] seg_addr,
    output logic [LEN_W-1:0]  seg_len,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    output logic [LEN_W-1:0]  rd_req_beats,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [ENT_W-1:0]  rsp_data,
    output logic              done,
    output logic              done_dnr,
    output logic [7:0]        done_code
);
    walk_st_e          st;
    logic [ADDR_W-1:0] p1_q, p2_q, list_q, ent_q;
    logic [LEN_W-1:0]  rem_q, slot_q, owed_q;
    logic [3:0]        mps_q;
    logic              err_q;

    logic [LEN_W-1:0]  pg_size, head_len, cap_len, burst_n, slot_last;
    logic              rem_gt_pg, p2_ok, ent_ok;
    logic [ADDR_W-1:0] ent_in;
    logic [LEN_W-1:0]  after_head;
    walk_status_t      stat;

    assign ent_in     = rsp_data[ADDR_W-1:0];
    assign after_head = rem_q - head_len;

    prp_seg_math #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) math_i (
        .page_sel (mps_q),
        .head_ptr (p1_q),
        .rem      (rem_q),
        .pg_size  (pg_size),
        .head_len (head_len),
        .cap_len  (cap_len),
        .burst_n  (burst_n),
        .slot_last(slot_last),
        .rem_gt_pg(rem_gt_pg)
    );

    prp_ptr_check #(.ADDR_W(ADDR_W)) p2chk_i (
        .page_sel(mps_q), .ptr(p2_q), .usable(p2_ok)
    );

    prp_ptr_check #(.ADDR_W(ADDR_W)) entchk_i (
        .page_sel(mps_q), .ptr(ent_in), .usable(ent_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            p1_q   <= '0;
            p2_q   <= '0;
            list_q <= '0;
            ent_q  <= '0;
            rem_q  <= '0;
            slot_q <= '0;
            owed_q <= '0;
            mps_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    p1_q  <= first_ptr;
                    p2_q  <= second_ptr;
                    rem_q <= xfer_len;
                    mps_q <= page_sel;
                    err_q <= (first_ptr == '0);
                    if (first_ptr == '0 || xfer_len == '0) st <= ST_FIN;
                    else                                   st <= ST_HEAD;
                end
                ST_HEAD: if (seg_ready) begin
                    rem_q <= after_head;
                    if (after_head == '0) begin
                        st <= ST_FIN;
                    end else if (p2_q == '0) begin
                        err_q <= 1'b1;
                        st    <= ST_FIN;
                    end else if (after_head <= pg_size) begin
                        err_q <= !p2_ok;
                        st    <= p2_ok ? ST_TAIL : ST_FIN;
                    end else begin
                        list_q <= p2_q;
                        st     <= ST_LREQ;
                    end
                end
                ST_TAIL: if (seg_ready) st <= ST_FIN;
                ST_LREQ: if (rd_req_ready) begin
                    owed_q <= burst_n;
                    slot_q <= '0;
                    st     <= ST_LENT;
                end
                ST_LENT: if (rsp_valid) begin
                    owed_q <= owed_q - 1'b1;
                    if (!ent_ok) begin
                        err_q <= 1'b1;
                        st    <= ST_DRAIN;
                    end else if (slot_q == slot_last && rem_gt_pg) begin
                        list_q <= ent_in;
                        st     <= ST_LREQ;
                    end else begin
                        ent_q <= ent_in;
                        st    <= ST_LSEG;
                    end
                end
                ST_LSEG: if (seg_ready) begin
                    rem_q  <= rem_q - cap_len;
                    slot_q <= slot_q + 1'b1;
                    st     <= (rem_q == cap_len) ? ST_FIN : ST_LENT;
                end
                ST_DRAIN: begin
                    if (owed_q == '0)   st <= ST_FIN;
                    else if (rsp_valid) owed_q <= owed_q - 1'b1;
                end
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        seg_valid    = (st == ST_HEAD) || (st == ST_TAIL) || (st == ST_LSEG);
        seg_addr     = (st == ST_HEAD) ? p1_q : (st == ST_TAIL) ? p2_q : ent_q;
        seg_len      = (st == ST_HEAD) ? head_len : (st == ST_TAIL) ? rem_q : cap_len;
        rd_req_valid = (st == ST_LREQ);
        rd_req_addr  = list_q;
        rd_req_beats = burst_n;
        rsp_ready    = (st == ST_LENT) || (st == ST_DRAIN);
        stat.dnr     = err_q;
        stat.code    = err_q ? CODE_BAD_FIELD : CODE_OK;
        done         = (st == ST_FIN);
        done_dnr     = stat.dnr;
        done_code    = stat.code;
    end
endmodule

// File: rtl/prp_walker_chk.sv
module prp_walker_chk import prp_walk_pkg::*; #(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              seg_valid,
    input logic              seg_ready,
    input logic [ADDR_W-1:0] seg_addr,
    input logic [LEN_W-1:0]  seg_len,
    input logic              rd_req_valid,
    input logic              rd_req_ready,
    input logic [ADDR_W-1:0] rd_req_addr,
    input logic [LEN_W-1:0]  rd_req_beats,
    input logic              rsp_ready,
    input logic              done,
    input logic              err_q,
    input logic [3:0]        mps_q
);
    logic [LEN_W-1:0] pg;
    assign pg = {{(LEN_W-1){1'b0}}, 1'b1} << pg_shift(mps_q);

    a_r10_seg_hold: assert property (@(posedge clk) disable iff (rst)
        seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len));

    a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_beats));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_seg_len_range: assert property (@(posedge clk) disable iff (rst)
        seg_valid |-> seg_len != '0 && seg_len <= pg);

    a_r5_req_count: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> rd_req_beats != '0 && rd_req_beats <= (pg >> 3));

    a_r8_silent_after_err: assert property (@(posedge clk) disable iff (rst)
        err_q |-> !seg_valid && !rd_req_valid);

    a_r10_one_activity: assert property (@(posedge clk) disable iff (rst)
        $onehot0({seg_valid, rd_req_valid, rsp_ready, done}));
endmodule

bind prp_walker prp_walker_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
    .clk(clk), .rst(rst),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_req_beats(rd_req_beats),
    .rsp_ready(rsp_ready), .done(done), .err_q(err_q), .mps_q(mps_q)
);

// File: tb/prp_walker_tb_top.sv
module prp_walker_tb_top;
    localparam int AW = 64;
    localparam int LW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] first_ptr = '0, second_ptr = '0;
    logic [LW-1:0] xfer_len = '0;
    logic [3:0]    page_sel = '0;
    logic          seg_valid, seg_ready;
    logic [AW-1:0] seg_addr;
    logic [LW-1:0] seg_len;
    logic          rd_req_valid, rd_req_ready;
    logic [AW-1:0] rd_req_addr;
    logic [LW-1:0] rd_req_beats;
    logic          rsp_valid, rsp_ready;
    logic [63:0]   rsp_data;
    logic          done, done_dnr;
    logic [7:0]    done_code;

    always #10 clk = ~clk;

    prp_walker #(.ADDR_W(AW), .LEN_W(LW)) dut_i (
        .clk(clk), .rst(rst), .start(start),
        .first_ptr(first_ptr), .second_ptr(second_ptr), .xfer_len(xfer_len), .page_sel(page_sel),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_req_beats(rd_req_beats),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .done(done), .done_dnr(done_dnr), .done_code(done_code)
    );

    int total = 0;
    int bad   = 0;

    logic [63:0] e_sa [0:2047];
    logic [31:0] e_sl [0:2047];
    logic [63:0] e_ra [0:15];
    logic [31:0] e_rn [0:15];
    int e_ns, e_nr, e_beats;
    bit e_err, e_direct;

    int g_ns, g_nr, beat_g;
    int bad_at = -1;
    bit bad_zero;

    logic [63:0] rq_a [0:15];
    logic [31:0] rq_n [0:15];
    int rq_wr, rq_rd;
    bit have;
    logic [63:0] cur_a;
    logic [31:0] cur_n, cur_k;

    function automatic logic [63:0] ent_val(input logic [63:0] a);
        return (a + 64'd8) << 16;
    endfunction

    function automatic logic [63:0] beat_val(input logic [63:0] a, input int g);
        logic [63:0] v;
        v = ent_val(a);
        if (g == bad_at) v = bad_zero ? 64'd0 : (v | 64'h800);
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference walk computed from the requirements
    task automatic build_exp(input logic [63:0] p1, input logic [63:0] p2,
                             input logic [31:0] len, input int m);
        longint unsigned pg, f, rem, epp, lst, v, idx, need, n, l;
        int g;
        e_ns = 0; e_nr = 0; e_err = 0; e_beats = 0; e_direct = 0;
        pg = 64'd1 << (12 + m);
        if (p1 == 0) begin e_err = 1; return; end
        if (len == 0) return;
        f = pg - (p1 % pg);
        if (f > len) f = len;
        e_sa[0] = p1; e_sl[0] = 32'(f); e_ns = 1;
        rem = len - f;
        if (rem == 0) return;
        if (p2 == 0) begin e_err = 1; return; end
        if (rem <= pg) begin
            if (p2 % pg != 0) e_err = 1;
            else begin e_sa[1] = p2; e_sl[1] = 32'(rem); e_ns = 2; e_direct = 1; end
            return;
        end
        epp = pg / 8; lst = p2; idx = 0; g = 0;
        need = (rem + pg - 1) / pg; n = (need < epp) ? need : epp;
        e_ra[e_nr] = lst; e_rn[e_nr] = 32'(n); e_nr++; e_beats += int'(n);
        while (rem > 0) begin
            v = ent_val(lst + 8 * idx);
            if (g == bad_at) v = bad_zero ? 0 : (v | 64'h800);
            g++;
            if (v == 0 || v % pg != 0) begin e_err = 1; return; end
            if (idx == epp - 1 && rem > pg) begin
                lst = v; idx = 0;
                need = (rem + pg - 1) / pg; n = (need < epp) ? need : epp;
                e_ra[e_nr] = lst; e_rn[e_nr] = 32'(n); e_nr++; e_beats += int'(n);
            end else begin
                l = (rem < pg) ? rem : pg;
                e_sa[e_ns] = v; e_sl[e_ns] = 32'(l); e_ns++;
                rem -= l; idx++;
            end
        end
    endtask

    // segment consumer with periodic back-pressure
    initial begin
        int sr_cnt = 0;
        seg_ready = 1'b0;
        forever begin
            @(negedge clk);
            seg_ready = (sr_cnt % 3) != 2;
            sr_cnt++;
            #5;
            if (seg_valid && seg_ready) begin
                if (g_ns < e_ns) begin
                    string t;
                    t = (g_ns == 0) ? "R2" : (e_direct ? "R3" : "R6");
                    chk(seg_addr == e_sa[g_ns], t, "segment address", seg_addr, e_sa[g_ns]);
                    chk(seg_len == e_sl[g_ns], t, "segment length", 64'(seg_len), 64'(e_sl[g_ns]));
                end else begin
                    chk(1'b0, "R8", "unexpected segment", 64'(g_ns), 64'(e_ns));
                end
                g_ns++;
            end
        end
    end

    // list memory: accepts read requests, returns entries
    initial begin
        int rc = 0;
        rd_req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
        forever begin
            @(negedge clk);
            rd_req_ready = (rc % 4) != 1;
            if (!have && rq_rd < rq_wr) begin
                cur_a = rq_a[rq_rd]; cur_n = rq_n[rq_rd]; cur_k = 0;
                rq_rd++; have = 1;
            end
            rsp_valid = have && ((rc % 5) != 3);
            rsp_data  = have ? beat_val(cur_a + 64'(cur_k) * 8, beat_g) : 64'd0;
            rc++;
            #5;
            if (rd_req_valid && rd_req_ready) begin
                if (g_nr < e_nr) begin
                    chk(rd_req_addr == e_ra[g_nr], g_nr == 0 ? "R5" : "R7", "read address",
                        rd_req_addr, e_ra[g_nr]);
                    chk(rd_req_beats == e_rn[g_nr], g_nr == 0 ? "R5" : "R7", "read count",
                        64'(rd_req_beats), 64'(e_rn[g_nr]));
                end else begin
                    chk(1'b0, "R3", "unexpected read", 64'(g_nr), 64'(e_nr));
                end
                if (rq_wr < 16) begin
                    rq_a[rq_wr] = rd_req_addr; rq_n[rq_wr] = rd_req_beats; rq_wr++;
                end
                g_nr++;
            end
            if (rsp_valid && rsp_ready) begin
                cur_k++; beat_g++;
                if (cur_k == cur_n) have = 0;
            end
        end
    end

    task automatic run_case(input logic [63:0] p1, input logic [63:0] p2, input logic [31:0] len,
                            input int m, input int b_at, input bit b_zero, input bit poke,
                            input string tag);
        bit seen;
        bad_at = b_at; bad_zero = b_zero;
        build_exp(p1, p2, len, m);
        @(negedge clk);
        g_ns = 0; g_nr = 0; beat_g = 0; rq_wr = 0; rq_rd = 0; have = 0;
        first_ptr = p1; second_ptr = p2; xfer_len = len; page_sel = 4'(m);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 0;
        for (int i = 0; i < 20000; i++) begin
            #6;
            if (done) begin seen = 1; break; end
            if (poke && i == 7) begin
                // R10: a start while busy must not disturb the walk
                first_ptr = 64'd0; xfer_len = 32'd9; start = 1'b1;
            end else if (poke && i == 8) begin
                first_ptr = p1; xfer_len = len; start = 1'b0;
            end
            @(negedge clk);
        end
        chk(seen, tag, "completion seen", 64'(seen), 64'd1);
        chk(done_dnr == e_err, tag, "do-not-retry flag", 64'(done_dnr), 64'(e_err));
        chk(done_code == (e_err ? 8'h02 : 8'h00), tag, "status code",
            64'(done_code), e_err ? 64'h02 : 64'h00);
        chk(g_ns == e_ns, tag, "segment count", 64'(g_ns), 64'(e_ns));
        chk(g_nr == e_nr, tag, "read request count", 64'(g_nr), 64'(e_nr));
        chk(beat_g == e_beats, "R8", "entry beats consumed", 64'(beat_g), 64'(e_beats));
        @(negedge clk);
        #6;
        chk(!done, "R10", "done lasts one cycle", 64'(done), 64'd0);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                total++; bad++;
                $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [63:0] base1 = 64'h0000_0001_2000_0000;
        logic [63:0] base2 = 64'h0000_0000_0080_0000;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #6;
        chk(!seg_valid && !rd_req_valid && !rsp_ready && !done, "R10", "idle after reset",
            {60'd0, seg_valid, rd_req_valid, rsp_ready, done}, 64'd0);

        // R2 R3 R5 R6 R9: sweep head offsets and lengths around page edges
        for (int m = 0; m < 2; m++) begin
            for (int oi = 0; oi < 4; oi++) begin
                longint unsigned pg, off;
                pg  = 64'd1 << (12 + m);
                off = (oi == 0) ? 0 : (oi == 1) ? 8 : (oi == 2) ? pg / 2 : pg - 8;
                for (int li = 0; li < 6; li++) begin
                    longint unsigned len;
                    case (li)
                        0: len = 1;
                        1: len = pg - off;
                        2: len = pg - off + 1;
                        3: len = 2 * pg - off;
                        4: len = 2 * pg - off + 1;
                        default: len = 5 * pg + 3;
                    endcase
                    run_case(base1 + off, base2, 32'(len), m, -1, 0, 0, "R9");
                end
            end
        end

        // R1: zero first pointer
        run_case(64'd0, base2, 32'd5000, 0, -1, 0, 0, "R1");
        // R9: zero length
        run_case(base1, base2, 32'd0, 0, -1, 0, 0, "R9");
        // R4: missing second pointer, direct and list sizes
        run_case(base1 + 64'd100, 64'd0, 32'd4000, 0, -1, 0, 0, "R4");
        run_case(base1, 64'd0, 32'd40000, 0, -1, 0, 0, "R4");
        // R3: misaligned second pointer in direct mode
        run_case(base1 + 64'd16, base2 + 64'd8, 32'd4096, 0, -1, 0, 0, "R3");
        // R7: all slots of one list page used as data, no chain
        run_case(base1, base2, 32'(4096 * 513), 0, -1, 0, 1, "R7");
        // R7: chain on the final slot
        run_case(base1 + 64'd512, base2, 32'(4096 * 514), 0, -1, 0, 0, "R7");
        run_case(base1, base2, 32'(8192 * 1030), 1, -1, 0, 0, "R7");
        // R8: bad entries, early in a burst and on the chain slot
        run_case(base1, base2, 32'(4096 * 40), 0, 3, 1, 0, "R8");
        run_case(base1, base2, 32'(4096 * 40), 0, 0, 0, 0, "R8");
        run_case(base1, base2, 32'(4096 * 514), 0, 511, 0, 0, "R8");
        run_case(base1, base2, 32'(4096 * 514), 0, 512, 1, 0, "R8");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule